// File: doc/BRIEF.md
# Viterbi Survivor Traceback Unit

This block produces one decoded bit of a Viterbi decoder. It walks backwards through the survivor decisions that earlier add-compare-select updates stored. A start pulse begins the walk at the best state, the one with the lowest accumulated cost after the latest update. A down-counter is loaded from a traceback length that software sets at run time. On each step the unit reads one survivor bit for the current state and time column, forms the predecessor state from it and moves back one column.

When the counter reaches zero, the unit emits the decoded bit, which is the top bit of the state it has reached, together with a one-cycle valid strobe. The survivor store lives outside the block. It is a circular buffer of 64 columns with a combinational read port. The unit drives the column and state address, and the store returns the decision bit in the same cycle. The constraint length is also set at run time, from 3 up to a parameter maximum.

Top module: `vtrace_unit`

## Requirements
- R1: During and straight after reset, `valid_o`, `busy_o` and `bit_o` are 0.
- R2: A start accepted while idle puts `mem_rd_col_o` at `wr_col_i` and `mem_rd_state_o` at `best_state_i`, keeping only its low C−1 bits.
- R3: Each step replaces the state S with (S >> 1) | (b << (C−2)), kept to C−1 bits, where b is `mem_rd_bit_i` for the current column and state.
- R4: Each step moves the read column one lower, modulo 64, so column 0 is followed by column 63.
- R5: With a length L > 0 captured at clock edge t, `valid_o` is high for the single cycle after edge t+L.
- R6: The decoded bit `bit_o` equals bit C−2 of the final state.
- R7: A length of 0 raises `valid_o` in the cycle after the start edge, with bit C−2 of the masked start state, and `busy_o` stays low.
- R8: `valid_o` lasts one cycle for each accepted start, and a trace that has just finished is never followed by a second, unrequested strobe.
- R9: A start pulse while `busy_o` is high is ignored and does not change the running trace or its result.
- R10: The constraint length C (3 to MAX_K) is captured at start, so changing `k_len_i` during a trace has no effect on that trace.
- R11: `busy_o` is high from the start edge until the last step, and it is low whenever `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a traceback (taken only when idle) |
| tb_len_i | input | LEN_W | Number of traceback steps |
| best_state_i | input | MAX_K-1 | Minimum-cost state from the latest update |
| k_len_i | input | KW | Constraint length C, 3..MAX_K |
| wr_col_i | input | COL_W | Most recently written survivor column |
| mem_rd_col_o | output | COL_W | Survivor read column |
| mem_rd_state_o | output | MAX_K-1 | Survivor read state |
| mem_rd_bit_i | input | 1 | Survivor decision bit at the read address |
| bit_o | output | 1 | Decoded bit |
| valid_o | output | 1 | One-cycle strobe for `bit_o` |
| busy_o | output | 1 | A trace is in progress |

## Verification
The assertions assume that `k_len_i` lies between 3 and MAX_K whenever a start is taken. They also assume that the survivor store answers in the same cycle, so `mem_rd_bit_i` reflects the address being driven.

The stimulus uses only legal constraint lengths and models the store as a combinational array filled with random decisions. It sets the inputs and pulses start only at falling edges. Between traces it waits for the unit to go idle, except where it deliberately pulses start during a trace. In those extra pulses it also changes `k_len_i` and `best_state_i`, to show that a running trace ignores them.

// File: rtl/vtrace_pkg.sv
package vtrace_pkg;
    localparam int unsigned DEF_MAX_K = 7;
    localparam int unsigned DEF_LEN_W = 8;
    localparam int unsigned DEF_COL_W = 6;
endpackage

// File: rtl/vtrace_mask.sv
module vtrace_mask #(
    parameter int unsigned SW = 6,
    parameter int unsigned KW = 3
) (
    input  logic [SW-1:0] state_i,
    input  logic [KW-1:0] k_i,
    output logic [SW-1:0] state_o
);
    localparam logic [KW-1:0] K1 = KW'(1);

    logic [SW-1:0] keep;

    always_comb begin
        keep    = ~({SW{1'b1}} << (k_i - K1));
        state_o = state_i & keep;
    end
endmodule

// File: rtl/vtrace_pred.sv
module vtrace_pred #(
    parameter int unsigned SW = 6,
    parameter int unsigned KW = 3
) (
    input  logic [SW-1:0] state_i,
    input  logic          surv_i,
    input  logic [KW-1:0] k_i,
    output logic [SW-1:0] pred_o
);
    localparam logic [KW-1:0] K2 = KW'(2);

    logic [SW-1:0] shifted;
    logic [SW-1:0] top;
    logic [SW-1:0] trimmed;

    vtrace_mask #(.SW(SW), .KW(KW)) u_trim (
        .state_i (shifted),
        .k_i     (k_i),
        .state_o (trimmed)
    );

    always_comb begin
        shifted = state_i >> 1;
        top     = SW'(surv_i) << (k_i - K2);
        pred_o  = trimmed | top;
    end
endmodule

// File: rtl/vtrace_topbit.sv
module vtrace_topbit #(
    parameter int unsigned SW = 6,
    parameter int unsigned KW = 3
) (
    input  logic [SW-1:0] state_i,
    input  logic [KW-1:0] k_i,
    output logic          bit_o
);
    localparam logic [KW-1:0] K2 = KW'(2);

    logic [SW-1:0] pick;

    always_comb begin
        pick  = SW'(1) << (k_i - K2);
        bit_o = |(state_i & pick);
    end
endmodule

// File: rtl/vtrace_unit.sv
module vtrace_unit #(
    parameter int unsigned MAX_K = vtrace_pkg::DEF_MAX_K,
    parameter int unsigned LEN_W = vtrace_pkg::DEF_LEN_W,
    parameter int unsigned COL_W = vtrace_pkg::DEF_COL_W,
    localparam int unsigned SW   = MAX_K - 1,
    localparam int unsigned KW   = $clog2(MAX_K + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] tb_len_i,
    input  logic [SW-1:0]    best_state_i,
    input  logic [KW-1:0]    k_len_i,
    input  logic [COL_W-1:0] wr_col_i,
    output logic [COL_W-1:0] mem_rd_col_o,
    output logic [SW-1:0]    mem_rd_state_o,
    input  logic             mem_rd_bit_i,
    output logic             bit_o,
    output logic             valid_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic             valid;
        logic             dbit;
        logic [LEN_W-1:0] cnt;
        logic [COL_W-1:0] col;
        logic [SW-1:0]    st;
        logic [KW-1:0]    k;
    } trace_t;

    trace_t q, d;

    logic [SW-1:0] start_st;
    logic          start_bit;
    logic [SW-1:0] pred;
    logic          step_bit;

    vtrace_mask #(.SW(SW), .KW(KW)) u_start_mask (
        .state_i (best_state_i),
        .k_i     (k_len_i),
        .state_o (start_st)
    );

    vtrace_topbit #(.SW(SW), .KW(KW)) u_start_bit (
        .state_i (start_st),
        .k_i     (k_len_i),
        .bit_o   (start_bit)
    );

    vtrace_pred #(.SW(SW), .KW(KW)) u_pred (
        .state_i (q.st),
        .surv_i  (mem_rd_bit_i),
        .k_i     (q.k),
        .pred_o  (pred)
    );

    vtrace_topbit #(.SW(SW), .KW(KW)) u_step_bit (
        .state_i (pred),
        .k_i     (q.k),
        .bit_o   (step_bit)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.k   = k_len_i;
                d.col = wr_col_i;
                d.st  = start_st;
                d.cnt = tb_len_i;
                if (tb_len_i == '0) begin
                    d.valid = 1'b1;
                    d.dbit  = start_bit;
                end else begin
                    d.busy = 1'b1;
                end
            end
        end else begin
            d.st  = pred;
            d.col = q.col - COL_W'(1);
            d.cnt = q.cnt - LEN_W'(1);
            if (q.cnt == LEN_W'(1)) begin
                d.busy  = 1'b0;
                d.valid = 1'b1;
                d.dbit  = step_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_col_o   = q.col;
    assign mem_rd_state_o = q.st;
    assign bit_o          = q.dbit;
    assign valid_o        = q.valid;
    assign busy_o         = q.busy;

    // Column steps back by one modulo 64 on every busy cycle.
    assert_col_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (mem_rd_col_o == $past(mem_rd_col_o) - COL_W'(1)));

    // Strobe and busy never overlap.
    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    // A strobe is not repeated unless a zero-length start was taken.
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !(start_i && tb_len_i == '0)) |=> !valid_o);

    // A running trace always has steps left.
    assert_busy_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.cnt != '0));

    // Captured constraint length does not move while busy.
    assert_k_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(q.k));

    // State stays within C-1 bits while tracing.
    assert_state_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((mem_rd_state_o >> (q.k - KW'(1))) == '0));
endmodule

// File: tb/test_vtrace_unit.sv
module test_vtrace_unit;
    localparam int MAX_K = 7;
    localparam int LEN_W = 8;
    localparam int COL_W = 6;
    localparam int SW    = MAX_K - 1;
    localparam int KW    = $clog2(MAX_K + 1);
    localparam int COLS  = 1 << COL_W;
    localparam int NST   = 1 << SW;

    typedef struct {
        bit dbit;
        int at;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] tb_len_i = '0;
    logic [SW-1:0]    best_state_i = '0;
    logic [KW-1:0]    k_len_i = KW'(3);
    logic [COL_W-1:0] wr_col_i = '0;
    logic [COL_W-1:0] mem_rd_col_o;
    logic [SW-1:0]    mem_rd_state_o;
    logic             mem_rd_bit_i;
    logic             bit_o;
    logic             valid_o;
    logic             busy_o;

    logic [NST-1:0] surv [COLS];
    exp_t exp_q[$];
    int cyc = 0;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_rd_bit_i = surv[mem_rd_col_o][mem_rd_state_o];

    vtrace_unit #(.MAX_K(MAX_K), .LEN_W(LEN_W), .COL_W(COL_W)) i_vtrace_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tb_len_i(tb_len_i),
        .best_state_i(best_state_i), .k_len_i(k_len_i), .wr_col_i(wr_col_i),
        .mem_rd_col_o(mem_rd_col_o), .mem_rd_state_o(mem_rd_state_o),
        .mem_rd_bit_i(mem_rd_bit_i), .bit_o(bit_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic bit ref_trace(input int best, input int len, input int k, input int col);
        int s = best & ((1 << (k - 1)) - 1);
        int c = col;
        int b;
        for (int i = 0; i < len; i++) begin
            b = int'(surv[c][s]);
            s = (s >> 1) | (b << (k - 2));
            c = (c + COLS - 1) % COLS;
        end
        return bit'((s >> (k - 2)) & 1);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(bit_o == e.dbit, "R6 decoded bit", int'(bit_o), int'(e.dbit));
                chk(cyc == e.at, "R5 strobe cycle", cyc, e.at);
                chk(!busy_o, "R11 busy low at strobe", int'(busy_o), 0);
            end
        end
    end

    task automatic run_trace(input int best, input int len, input int k, input int col, input bit poke);
        int mbest;
        int b;
        int nst;
        exp_t e;
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        mbest = best & ((1 << (k - 1)) - 1);
        best_state_i = SW'(best);
        tb_len_i     = LEN_W'(len);
        k_len_i      = KW'(k);
        wr_col_i     = COL_W'(col);
        start_i      = 1'b1;
        e.dbit = ref_trace(best, len, k, col);
        e.at   = cyc + 1 + len;
        exp_q.push_back(e);
        @(negedge clk);
        start_i      = 1'b0;
        best_state_i = ~SW'(best);
        wr_col_i     = ~COL_W'(col);
        k_len_i      = KW'((k == 3) ? 7 : 3);   // R10: changed mid-trace
        if (len == 0) begin
            chk(!busy_o, "R7 busy stays low", int'(busy_o), 0);
        end else begin
            chk(busy_o, "R11 busy after start", int'(busy_o), 1);
            chk(int'(mem_rd_col_o) == col, "R2 first column", int'(mem_rd_col_o), col);
            chk(int'(mem_rd_state_o) == mbest, "R2 first state", int'(mem_rd_state_o), mbest);
            if (len >= 2) begin
                b = int'(surv[col][mbest]);
                nst = (mbest >> 1) | (b << (k - 2));
                @(negedge clk);
                chk(int'(mem_rd_state_o) == nst, "R3 predecessor", int'(mem_rd_state_o), nst);
                chk(int'(mem_rd_col_o) == (col + COLS - 1) % COLS, "R4 column step",
                    int'(mem_rd_col_o), (col + COLS - 1) % COLS);
            end
            if (poke && len >= 5) begin
                best_state_i = SW'(NST - 1);
                tb_len_i     = '0;                  // R9: would strobe if taken
                start_i      = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(busy_o, "R9 start ignored while busy", int'(busy_o), 1);
            end
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < COLS; c++) surv[c] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        chk(!valid_o && !busy_o && !bit_o, "R1 reset outputs",
            int'({valid_o, busy_o, bit_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !busy_o, "R1 idle after reset", int'({valid_o, busy_o}), 0);

        run_trace(6'b100000, 0, 7, 10, 1'b0);   // R7 top bit one
        run_trace(6'b011111, 0, 7, 10, 1'b0);   // R7 top bit zero
        run_trace(6'b111101, 0, 3, 4, 1'b0);    // R7 masked to 2 bits
        run_trace(5, 1, 4, 0, 1'b0);            // R4 wrap on single step
        run_trace(6'b111011, 5, 4, 2, 1'b1);    // R2 masking, R9, R4 wrap
        run_trace(17, 20, 7, 63, 1'b1);
        run_trace(3, 100, 5, 1, 1'b1);
        run_trace(1, 255, 3, 30, 1'b0);
        run_trace(42, 64, 7, 0, 1'b1);
        for (int i = 0; i < 40; i++)
            run_trace(int'($urandom % NST), int'($urandom % 40), 3 + int'($urandom % 5),
                      int'($urandom % COLS), i[0]);

        // R8: back-to-back zero-length starts, one strobe each
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            exp_t e;
            best_state_i = SW'(i * 21);
            tb_len_i     = '0;
            k_len_i      = KW'(7);
            start_i      = 1'b1;
            e.dbit = ref_trace(i * 21, 0, 7, 0);
            e.at   = cyc + 1;
            exp_q.push_back(e);
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all strobes seen", exp_q.size(), 0);
        chk(!valid_o, "R8 strobe ended", int'(valid_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule